// File: doc/BRIEF.md
# DMA Channel Address and Terminal-Count Unit

This block holds the transfer state for four DMA channels. Each channel has a 16-bit memory address and a 14-bit down-counter, both written by the CPU through a single register-write port. The counter is loaded with the number of bytes minus one. Each time the arbiter reports a completed DMA cycle for the granted channel, that channel's address steps up by one and its counter steps down by one. During the last transfer of a block the unit raises a terminal-count strobe. Every 128 transfers before the end it raises a mark strobe.

A write-only control register holds four policy bits and the four channel enables. When stop-on-terminal-count is set, a channel turns itself off after its last transfer. When auto-load is set, channel 2 takes a fresh address and count from channel 3 at its terminal count, so that a block transfer repeats with no CPU write. Each terminal count sets a sticky status flag. A status-read strobe clears the flags. The register named by `xfer_ch` has its address and count shown on the select outputs, so the CPU or the arbiter can read them back.

Each channel runs a three-state machine. `CH_OFF` means the channel is disabled. `CH_RUN` means it is enabled with a nonzero count. `CH_FINAL` means it is enabled with a count of zero, so its next transfer is the terminal one. The transitions are as follows:
- enable (a control write with the channel bit set) moves a channel from `CH_OFF` to `CH_RUN` or `CH_FINAL`, depending on its count.
- disable (a control write with the bit clear) moves a channel from any state to `CH_OFF`.
- count-reached-zero moves a channel from `CH_RUN` to `CH_FINAL`.
- count-rewritten moves a channel from `CH_RUN` or `CH_FINAL` to the state that matches the new count.
- stop-at-end moves a channel from `CH_FINAL` to `CH_OFF` when it transfers with stop set.
- wrap-or-reload moves a channel from `CH_FINAL` back to `CH_RUN` or `CH_FINAL` when it transfers without stop.

Top module: `dma_chan_tc_unit`

## Requirements
- R1: After reset, all channel enables, the four policy bits, the status flags, and every address and count are zero.
- R2: A write with `reg_sel[3]`=0 targets channel `reg_sel[2:1]`. When `reg_sel[0]`=0 it writes the 16-bit address from `reg_wdata`. When `reg_sel[0]`=1 it writes the count from `reg_wdata[13:0]`, and bits 15:14 are ignored. The new value appears on `sel_addr` or `sel_cnt` after the next clock edge.
- R3: A write with `reg_sel[3]`=1 loads the control register. Bits 3:0 are the enables for channels 3..0, bit 4 is rotating priority, bit 5 is extended write, bit 6 is stop-on-terminal-count, and bit 7 is auto-load. All of these appear on the outputs after the next edge.
- R4: A transfer on an enabled channel adds one to its address, wrapping from 16'hFFFF to 16'h0000.
- R5: A transfer on an enabled channel subtracts one from its count. Without stop or reload, the count wraps from 0 to 14'h3FFF and the channel stays enabled.
- R6: `tc` is high in the same cycle as `xfer_done` when the granted channel is enabled and its count is zero. That channel's bit in `tc_flags` is set after the edge.
- R7: `mark` is high in the same cycle as `xfer_done` when the granted channel is enabled and the low 7 bits of its count are zero. It is therefore also high with every `tc`.
- R8: With stop-on-terminal-count set, the terminal transfer clears that channel's enable. Later transfers on that channel change neither its address nor its count, and raise no `tc`.
- R9: A transfer reported for a disabled channel changes nothing and raises neither `tc` nor `mark`.
- R10: With auto-load set, the terminal transfer of channel 2 loads channel 3's address and count into channel 2, which then stays enabled unless stop is set. Channel 3 is left unchanged.
- R11: `stat_rd` clears `tc_flags` after the edge. A terminal count in the same cycle still sets its flag.
- R12: A CPU write to a channel's address or count in the same cycle as a transfer on that channel takes priority over the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select (see R2, R3) |
| reg_wdata | input | 16 | Write data |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| xfer_done | input | 1 | A DMA cycle completed for `xfer_ch` |
| xfer_ch | input | 2 | Granted channel; also selects the readback |
| sel_addr | output | 16 | Address of channel `xfer_ch` |
| sel_cnt | output | 14 | Count of channel `xfer_ch` |
| tc | output | 1 | Terminal count, during the last transfer |
| mark | output | 1 | Modulo-128 mark strobe |
| chan_en | output | 4 | Channel enables |
| autoload_on | output | 1 | Auto-load policy bit |
| stop_on_tc | output | 1 | Stop-on-terminal-count policy bit |
| ext_write | output | 1 | Extended-write policy bit |
| rot_prio | output | 1 | Rotating-priority policy bit |
| tc_flags | output | 4 | Sticky terminal-count flags |

## Verification
`tc` and `mark` are combinational. They are due in the same cycle as the `xfer_done` that causes them, so the bench samples them two time units after driving the transfer and before the capturing edge. Address, count, enable, policy and flag updates are due exactly one edge later. A behavioural model in the bench advances on the same edge, and the model and the design are compared shortly before the following edge. The directed checks read the select outputs one cycle after each stimulus. No result is taken at a clock edge.

// File: rtl/dma_tc_pkg.sv
package dma_tc_pkg;
    localparam int NCH        = 4;
    localparam int CHW        = $clog2(NCH);
    localparam int SEL_W      = CHW + 2;
    localparam int RELOAD_DST = 2;
    localparam int RELOAD_SRC = 3;
    // control-register bit positions (software-visible)
    localparam int CB_ROT     = 4;
    localparam int CB_EXT     = 5;
    localparam int CB_STOP    = 6;
    localparam int CB_AUTO    = 7;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_RUN   = 2'd1,
        CH_FINAL = 2'd2
    } chan_st_e;
endpackage

// File: rtl/dma_mode_reg.sv
module dma_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ld,
    input  logic auto_in,
    input  logic stop_in,
    input  logic ext_in,
    input  logic rot_in,
    output logic auto_q,
    output logic stop_q,
    output logic ext_q,
    output logic rot_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            auto_q <= 1'b0;
            stop_q <= 1'b0;
            ext_q  <= 1'b0;
            rot_q  <= 1'b0;
        end else if (ld) begin
            auto_q <= auto_in;
            stop_q <= stop_in;
            ext_q  <= ext_in;
            rot_q  <= rot_in;
        end
    end

    a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable({auto_q, stop_q, ext_q, rot_q}));
endmodule

// File: rtl/dma_tc_status.sv
module dma_tc_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] tc_vec,
    input  logic         rd,
    output logic [N-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (rd ? '0 : flags) | tc_vec;
    end

    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_vec != '0) |=> ((flags & $past(tc_vec)) == $past(tc_vec)));
    a_r11_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && tc_vec == '0) |=> (flags == '0));
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && tc_vec == '0) |=> $stable(flags));
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
    import dma_tc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    parameter int MARK_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic              ld_mode,
    input  logic              mode_en,
    input  logic              stop_tc,
    input  logic              reload_on,
    input  logic [ADDR_W-1:0] wr_addr_val,
    input  logic [CNT_W-1:0]  wr_cnt_val,
    input  logic [ADDR_W-1:0] rl_addr,
    input  logic [CNT_W-1:0]  rl_cnt,
    input  logic              xfer,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              en_o,
    output logic              tc_o,
    output logic              mark_o
);
    chan_st_e          st_q, st_nx;
    logic              live, rl_take, cnt_zero_nx;
    logic [ADDR_W-1:0] addr_nx;
    logic [CNT_W-1:0]  cnt_nx;

    // outputs decoded from state
    always_comb begin
        en_o   = (st_q != CH_OFF);
        live   = xfer && en_o;
        tc_o   = xfer && (st_q == CH_FINAL);
        mark_o = live && (cnt_q[MARK_W-1:0] == '0);
    end

    assign rl_take = reload_on && tc_o;

    // datapath next values; CPU writes win over a same-cycle step
    always_comb begin
        addr_nx = addr_q;
        if (ld_addr)      addr_nx = wr_addr_val;
        else if (rl_take) addr_nx = rl_addr;
        else if (live)    addr_nx = addr_q + 1'b1;

        cnt_nx = cnt_q;
        if (ld_cnt)       cnt_nx = wr_cnt_val;
        else if (rl_take) cnt_nx = rl_cnt;
        else if (live)    cnt_nx = cnt_q - 1'b1;

        cnt_zero_nx = (cnt_nx == '0);
    end

    // next-state logic
    always_comb begin
        st_nx = st_q;
        if (ld_mode) begin
            st_nx = mode_en ? (cnt_zero_nx ? CH_FINAL : CH_RUN) : CH_OFF;
        end else begin
            unique case (st_q)
                CH_OFF:   st_nx = CH_OFF;
                CH_RUN:   st_nx = cnt_zero_nx ? CH_FINAL : CH_RUN;
                CH_FINAL: begin
                    if (live && stop_tc) st_nx = CH_OFF;
                    else                 st_nx = cnt_zero_nx ? CH_FINAL : CH_RUN;
                end
                default:  st_nx = CH_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            addr_q <= addr_nx;
            cnt_q  <= cnt_nx;
        end
    end

    a_r6_final_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_FINAL) |-> (cnt_q == '0));
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !ld_addr && !rl_take) |=> ((addr_q - $past(addr_q)) == ADDR_W'(1)));
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !ld_cnt && !rl_take) |=> (($past(cnt_q) - cnt_q) == CNT_W'(1)));
    a_r8_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o && stop_tc && !ld_mode) |=> !en_o);
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !en_o && !ld_addr && !ld_cnt) |=> ($stable(addr_q) && $stable(cnt_q)));
    a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_take && !ld_addr && !ld_cnt) |=> (addr_q == $past(rl_addr) && cnt_q == $past(rl_cnt)));
endmodule

// File: rtl/dma_chan_tc_unit.sv
module dma_chan_tc_unit
    import dma_tc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 14,
    parameter int MARK_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              stat_rd,
    input  logic              xfer_done,
    input  logic [CHW-1:0]    xfer_ch,
    output logic [ADDR_W-1:0] sel_addr,
    output logic [CNT_W-1:0]  sel_cnt,
    output logic              tc,
    output logic              mark,
    output logic [NCH-1:0]    chan_en,
    output logic              autoload_on,
    output logic              stop_on_tc,
    output logic              ext_write,
    output logic              rot_prio,
    output logic [NCH-1:0]    tc_flags
);
    logic              ld_mode;
    logic [CHW-1:0]    hit_ch;
    logic [NCH-1:0]    tc_vec, mark_vec;
    logic [ADDR_W-1:0] addr_arr [NCH];
    logic [CNT_W-1:0]  cnt_arr  [NCH];

    assign ld_mode = reg_we && reg_sel[SEL_W-1];
    assign hit_ch  = reg_sel[CHW:1];

    dma_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (ld_mode),
        .auto_in (reg_wdata[CB_AUTO]),
        .stop_in (reg_wdata[CB_STOP]),
        .ext_in  (reg_wdata[CB_EXT]),
        .rot_in  (reg_wdata[CB_ROT]),
        .auto_q  (autoload_on),
        .stop_q  (stop_on_tc),
        .ext_q   (ext_write),
        .rot_q   (rot_prio)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ld_a, ld_c, rl_on;
        assign ld_a = reg_we && !reg_sel[SEL_W-1] && (hit_ch == CHW'(g)) && !reg_sel[0];
        assign ld_c = reg_we && !reg_sel[SEL_W-1] && (hit_ch == CHW'(g)) &&  reg_sel[0];
        if (g == RELOAD_DST) begin : g_rl
            assign rl_on = autoload_on;
        end else begin : g_norl
            assign rl_on = 1'b0;
        end

        dma_chan_slot #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .MARK_W (MARK_W)
        ) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .ld_addr     (ld_a),
            .ld_cnt      (ld_c),
            .ld_mode     (ld_mode),
            .mode_en     (reg_wdata[g]),
            .stop_tc     (stop_on_tc),
            .reload_on   (rl_on),
            .wr_addr_val (reg_wdata),
            .wr_cnt_val  (reg_wdata[CNT_W-1:0]),
            .rl_addr     (addr_arr[RELOAD_SRC]),
            .rl_cnt      (cnt_arr[RELOAD_SRC]),
            .xfer        (xfer_done && (xfer_ch == CHW'(g))),
            .addr_q      (addr_arr[g]),
            .cnt_q       (cnt_arr[g]),
            .en_o        (chan_en[g]),
            .tc_o        (tc_vec[g]),
            .mark_o      (mark_vec[g])
        );
    end

    dma_tc_status #(.N(NCH)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .tc_vec (tc_vec),
        .rd     (stat_rd),
        .flags  (tc_flags)
    );

    always_comb begin
        sel_addr = addr_arr[xfer_ch];
        sel_cnt  = cnt_arr[xfer_ch];
        tc       = |tc_vec;
        mark     = |mark_vec;
    end

    a_r6_one_tc: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tc_vec));
    a_r7_tc_marks: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> mark);
    a_r9_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done |-> (!tc && !mark));
endmodule

// File: tb/dma_chan_tc_unit_tb_top.sv
module dma_chan_tc_unit_tb_top;
    localparam int HALF = 4;   // 8-unit period: 125 MHz in ns

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        stat_rd = 1'b0;
    logic        xfer_done = 1'b0;
    logic [1:0]  xfer_ch = '0;
    logic [15:0] sel_addr;
    logic [13:0] sel_cnt;
    logic        tc, mark, autoload_on, stop_on_tc, ext_write, rot_prio;
    logic [3:0]  chan_en, tc_flags;

    int n_chk = 0;
    int n_err = 0;
    logic s_tc, s_mark;

    // behavioural reference state
    logic [15:0] m_addr [4];
    logic [13:0] m_cnt  [4];
    logic [3:0]  m_en = '0, m_flag = '0;
    logic        m_al = 0, m_stop = 0, m_ext = 0, m_rot = 0;

    always #HALF clk = ~clk;

    dma_chan_tc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .stat_rd(stat_rd), .xfer_done(xfer_done),
        .xfer_ch(xfer_ch), .sel_addr(sel_addr), .sel_cnt(sel_cnt), .tc(tc),
        .mark(mark), .chan_en(chan_en), .autoload_on(autoload_on),
        .stop_on_tc(stop_on_tc), .ext_write(ext_write), .rot_prio(rot_prio),
        .tc_flags(tc_flags)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    // model update on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_cnt[i] = '0; end
            m_en = '0; m_flag = '0; m_al = 0; m_stop = 0; m_ext = 0; m_rot = 0;
        end else begin
            logic live, tcev;
            int c;
            c = int'(xfer_ch);
            live = xfer_done && m_en[c];
            tcev = live && (m_cnt[c] == 0);
            if (stat_rd) m_flag = '0;
            if (live) begin
                if (tcev && c == 2 && m_al) begin
                    m_addr[2] = m_addr[3];
                    m_cnt[2]  = m_cnt[3];
                end else begin
                    m_addr[c] = m_addr[c] + 16'd1;
                    m_cnt[c]  = m_cnt[c] - 14'd1;
                end
                if (tcev) begin
                    m_flag[c] = 1'b1;
                    if (m_stop) m_en[c] = 1'b0;
                end
            end
            if (reg_we) begin
                if (reg_sel[3]) begin
                    m_en = reg_wdata[3:0];
                    m_rot = reg_wdata[4]; m_ext = reg_wdata[5];
                    m_stop = reg_wdata[6]; m_al = reg_wdata[7];
                end else if (reg_sel[0]) m_cnt[reg_sel[2:1]] = reg_wdata[13:0];
                else                     m_addr[reg_sel[2:1]] = reg_wdata;
            end
        end
    end

    // compare every cycle, well before the next edge
    always begin
        @(negedge clk);
        #3;
        if (rst_n) begin
            int c;
            logic e_live;
            c = int'(xfer_ch);
            e_live = xfer_done && m_en[c];
            chk("R4 sel_addr", 32'(sel_addr), 32'(m_addr[c]));
            chk("R5 sel_cnt", 32'(sel_cnt), 32'(m_cnt[c]));
            chk("R6 tc", 32'(tc), 32'(e_live && m_cnt[c] == 0));
            chk("R7 mark", 32'(mark), 32'(e_live && m_cnt[c][6:0] == 0));
            chk("R8 chan_en", 32'(chan_en), 32'(m_en));
            chk("R11 tc_flags", 32'(tc_flags), 32'(m_flag));
            chk("R3 policy", 32'({autoload_on, stop_on_tc, ext_write, rot_prio}),
                32'({m_al, m_stop, m_ext, m_rot}));
        end
    end

    task automatic cyc(input logic we, input logic [3:0] sel, input logic [15:0] wd,
                       input logic xd, input logic [1:0] xc, input logic rd);
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = wd;
        xfer_done = xd; xfer_ch = xc; stat_rd = rd;
        #2;
        s_tc = tc; s_mark = mark;
        @(posedge clk);
        #1;
        reg_we = 0; xfer_done = 0; stat_rd = 0;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [15:0] wd);
        cyc(1'b1, sel, wd, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic xf(input logic [1:0] c);
        cyc(1'b0, 4'h0, 16'h0, 1'b1, c, 1'b0);
    endtask

    task automatic look(input logic [1:0] c);
        @(negedge clk);
        xfer_ch = c;
        #3;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(2 * HALF * 200000);
        n_err++;
        $display("FAIL watchdog got=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        look(0);
        chk("R1 chan_en", 32'(chan_en), 0);
        chk("R1 flags", 32'(tc_flags), 0);
        chk("R1 addr", 32'(sel_addr), 0);
        chk("R1 cnt", 32'(sel_cnt), 0);
        chk("R1 policy", 32'({autoload_on, stop_on_tc, ext_write, rot_prio}), 0);

        wr(4'h0, 16'hFFFE);
        wr(4'h1, 16'hC002);              // bits 15:14 ignored
        look(0);
        chk("R2 addr", 32'(sel_addr), 32'h0000FFFE);
        chk("R2 cnt", 32'(sel_cnt), 32'd2);

        wr(4'h8, 16'h0001);
        look(0);
        chk("R3 enable", 32'(chan_en), 32'h1);

        xf(0);
        chk("R6 no early tc", 32'(s_tc), 0);
        look(0);
        chk("R4 step", 32'(sel_addr), 32'h0000FFFF);
        chk("R5 step", 32'(sel_cnt), 32'd1);
        xf(0);
        look(0);
        chk("R4 wrap", 32'(sel_addr), 32'h0);
        xf(0);
        chk("R6 tc", 32'(s_tc), 1);
        chk("R7 mark at tc", 32'(s_mark), 1);
        look(0);
        chk("R5 cnt wrap", 32'(sel_cnt), 32'h3FFF);
        chk("R5 stays on", 32'(chan_en), 32'h1);
        chk("R6 flag", 32'(tc_flags), 32'h1);

        cyc(1'b0, 4'h0, 16'h0, 1'b0, 2'd0, 1'b1);
        look(0);
        chk("R11 clear", 32'(tc_flags), 0);

        wr(4'h3, 16'h0000);
        wr(4'h8, 16'h0003);
        cyc(1'b0, 4'h0, 16'h0, 1'b1, 2'd1, 1'b1);
        chk("R6 tc ch1", 32'(s_tc), 1);
        look(1);
        chk("R11 set wins", 32'(tc_flags), 32'h2);

        wr(4'h1, 16'h0082);
        xf(0);
        chk("R7 no mark", 32'(s_mark), 0);
        xf(0);
        xf(0);
        chk("R7 mark 128", 32'(s_mark), 1);
        chk("R7 no tc", 32'(s_tc), 0);

        wr(4'h8, 16'h0043);
        wr(4'h3, 16'h0000);
        xf(1);
        chk("R8 tc", 32'(s_tc), 1);
        look(1);
        chk("R8 disabled", 32'(chan_en), 32'h1);
        xf(1);
        chk("R8 no tc", 32'(s_tc), 0);
        look(1);
        chk("R8 addr held", 32'(sel_addr), 32'h2);
        chk("R8 cnt held", 32'(sel_cnt), 32'h3FFF);

        xf(3);
        chk("R9 no tc", 32'(s_tc), 0);
        chk("R9 no mark", 32'(s_mark), 0);
        look(3);
        chk("R9 addr held", 32'(sel_addr), 0);

        cyc(1'b1, 4'h0, 16'h5000, 1'b1, 2'd0, 1'b0);
        look(0);
        chk("R12 write wins", 32'(sel_addr), 32'h5000);

        wr(4'h6, 16'h1234);
        wr(4'h7, 16'h0005);
        wr(4'h4, 16'h9000);
        wr(4'h5, 16'h0001);
        wr(4'h8, 16'h0084);
        xf(2);
        xf(2);
        chk("R10 tc", 32'(s_tc), 1);
        look(2);
        chk("R10 addr", 32'(sel_addr), 32'h1234);
        chk("R10 cnt", 32'(sel_cnt), 32'h5);
        chk("R10 enabled", 32'(chan_en), 32'h4);
        look(3);
        chk("R10 src addr", 32'(sel_addr), 32'h1234);
        chk("R10 src cnt", 32'(sel_cnt), 32'h5);

        wr(4'h8, 16'h0030);
        look(0);
        chk("R3 ext", 32'(ext_write), 1);
        chk("R3 rot", 32'(rot_prio), 1);
        chk("R3 off", 32'(chan_en), 0);

        for (int i = 0; i < 4; i++) wr(4'(2 * i + 1), 16'(i + 1));
        wr(4'h8, 16'h008F);
        for (int i = 0; i < 400; i++) begin
            logic [1:0] c;
            c = 2'((i * 7 + i / 5) % 4);
            if (i % 41 == 0)      cyc(1'b1, 4'(2 * (i % 4) + 1), 16'(i % 9), 1'b1, c, 1'b0);
            else if (i % 97 == 0) cyc(1'b1, 4'h8, 16'(8'hC0 | (i % 16)), 1'b0, c, 1'b0);
            else                  cyc(1'b0, 4'h0, 16'h0, (i % 3) != 0, c, (i % 17) == 0);
        end
        look(0);
        finish_run();
    end
endmodule